// File: doc/BRIEF.md
# Sixteen-Function Bitwise Logic Unit

This block applies one of the sixteen two-input Boolean functions to every bit pair of two equal-width operands and captures the outcome in a destination register. A four-bit function code picks the function. Each bit position is evaluated on its own, so no value passes between bit positions. The unit covers the full function set. Besides the usual AND, OR and XOR forms, it includes constants, pass-through, complements and the selective set and selective clear forms. Callers use these forms to force or strip chosen bits of one operand under a mask held in the other.

On a rising clock edge with the load enable high, the register takes the new result. With the enable low, it keeps its value. A synchronous reset clears the register and has priority over a load in the same cycle.

Top module: `logic_uop_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears result_q to all zeros, and this takes priority over op_en in the same cycle.
- R2: With rst low and op_en high at a rising edge, result_q takes the selected function of opnd_a and opnd_b from that edge, visible one cycle after the inputs are presented.
- R3: With rst low and op_en low at a rising edge, result_q keeps its value whatever fn_code, opnd_a and opnd_b are.
- R4: Code 0 loads all zeros and code 15 loads all ones, for any operands.
- R5: Code 1 loads A AND B, code 7 loads A OR B, code 6 loads A XOR B and code 9 loads A XNOR B.
- R6: Code 8 loads A NOR B and code 14 loads A NAND B.
- R7: Code 3 loads A unchanged, code 5 loads B unchanged, code 12 loads NOT A and code 10 loads NOT B.
- R8: Code 2 loads A AND NOT B, and code 4 loads NOT A AND B (selective clear).
- R9: Code 11 loads A OR NOT B, and code 13 loads NOT A OR B (selective set).
- R10: Each result bit depends only on the operand bits at the same position; no carry or borrow passes between positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_en | input | 1 | Load enable for the destination register |
| fn_code | input | 4 | Function code, 0 to 15 |
| opnd_a | input | WIDTH | First operand A |
| opnd_b | input | WIDTH | Second operand B |
| result_q | output | WIDTH | Destination register contents |

## Verification
Reset and load can fall in the same cycle. The bench provokes this by raising rst together with op_en and code 15, the all-ones function. In that cycle the result must read all zeros, which shows that the clear took priority over the load. A hold cycle that follows a load is also driven with changed operands and a changed code, and the register must keep the loaded value.

// File: rtl/lu_pkg.sv
package lu_pkg;

    localparam int FN_W = 4;

    typedef enum logic [FN_W-1:0] {
        FN_ZERO   = 4'd0,
        FN_AND    = 4'd1,
        FN_A_NB   = 4'd2,
        FN_PASS_A = 4'd3,
        FN_NA_B   = 4'd4,
        FN_PASS_B = 4'd5,
        FN_XOR    = 4'd6,
        FN_OR     = 4'd7,
        FN_NOR    = 4'd8,
        FN_XNOR   = 4'd9,
        FN_NOT_B  = 4'd10,
        FN_A_ONB  = 4'd11,
        FN_NOT_A  = 4'd12,
        FN_NA_OB  = 4'd13,
        FN_NAND   = 4'd14,
        FN_ONES   = 4'd15
    } lu_fn_e;

endpackage

// File: rtl/lu_bit_slice.sv
// One bit position: the function code is read as a truth table.
// Bit 0 of the code is the output for a=1,b=1; bit 3 for a=0,b=0.
module lu_bit_slice
    import lu_pkg::*;
(
    input  lu_fn_e truth,
    input  logic   a,
    input  logic   b,
    output logic   y
);
    always_comb begin
        unique case ({a, b})
            2'b11:   y = truth[0];
            2'b10:   y = truth[1];
            2'b01:   y = truth[2];
            default: y = truth[3];
        endcase
    end
endmodule

// File: rtl/lu_func_array.sv
module lu_func_array
    import lu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  lu_fn_e           fn_sel,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        lu_bit_slice u_slice (
            .truth (fn_sel),
            .a     (a[i]),
            .b     (b[i]),
            .y     (y[i])
        );
    end
endmodule

// File: rtl/lu_dest_reg.sv
module lu_dest_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/logic_uop_unit.sv
module logic_uop_unit
    import lu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_en,
    input  logic [FN_W-1:0]  fn_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result_q
);
    lu_fn_e           fn_sel;
    logic [WIDTH-1:0] fn_out;

    assign fn_sel = lu_fn_e'(fn_code);

    lu_func_array #(.WIDTH(WIDTH)) u_array (
        .fn_sel (fn_sel),
        .a      (opnd_a),
        .b      (opnd_b),
        .y      (fn_out)
    );

    lu_dest_reg #(.WIDTH(WIDTH)) u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (op_en),
        .d    (fn_out),
        .q    (result_q)
    );
endmodule

// File: rtl/lu_unit_checks.sv
module lu_unit_checks #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             op_en,
    input logic [3:0]       fn_code,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] result_q
);
    logic ld;
    assign ld = !rst && op_en;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (result_q == '0));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!op_en) |=> $stable(result_q));

    p_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (ld && fn_code == 4'd0) |=> (result_q == '0));

    p_ones_r4: assert property (@(posedge clk) disable iff (rst)
        (ld && fn_code == 4'd15) |=> (result_q == '1));

    p_and_r5: assert property (@(posedge clk) disable iff (rst)
        (ld && fn_code == 4'd1) |=> (result_q == ($past(opnd_a) & $past(opnd_b))));

    p_xor_r5: assert property (@(posedge clk) disable iff (rst)
        (ld && fn_code == 4'd6) |=> (result_q == ($past(opnd_a) ^ $past(opnd_b))));

    p_nand_r6: assert property (@(posedge clk) disable iff (rst)
        (ld && fn_code == 4'd14) |=> (result_q == ~($past(opnd_a) & $past(opnd_b))));

    p_pass_a_r7: assert property (@(posedge clk) disable iff (rst)
        (ld && fn_code == 4'd3) |=> (result_q == $past(opnd_a)));

    p_selclr_r8: assert property (@(posedge clk) disable iff (rst)
        (ld && fn_code == 4'd2) |=> (result_q == ($past(opnd_a) & ~$past(opnd_b))));

    p_selset_r9: assert property (@(posedge clk) disable iff (rst)
        (ld && fn_code == 4'd11) |=> (result_q == ($past(opnd_a) | ~$past(opnd_b))));
endmodule

bind logic_uop_unit lu_unit_checks #(.WIDTH(WIDTH)) u_checks (
    .clk      (clk),
    .rst      (rst),
    .op_en    (op_en),
    .fn_code  (fn_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .result_q (result_q)
);

// File: tb/logic_uop_unit_bench.sv
`timescale 1ns/1ps
module logic_uop_unit_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_en = 1'b0;
    logic [3:0]   fn_code = '0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    logic_uop_unit #(.WIDTH(W)) u_logic_uop_unit (
        .clk      (clk),
        .rst      (rst),
        .op_en    (op_en),
        .fn_code  (fn_code),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .result_q (result_q)
    );

    function automatic logic [W-1:0] model(input int code, input logic [W-1:0] a, input logic [W-1:0] b);
        case (code)
            0:  return '0;
            1:  return a & b;
            2:  return a & ~b;
            3:  return a;
            4:  return ~a & b;
            5:  return b;
            6:  return a ^ b;
            7:  return a | b;
            8:  return ~(a | b);
            9:  return ~(a ^ b);
            10: return ~b;
            11: return a | ~b;
            12: return ~a;
            13: return ~a | b;
            14: return ~(a & b);
            default: return '1;
        endcase
    endfunction

    function automatic string req_tag(input int code);
        case (code)
            0, 15:        return "R4";
            1, 6, 7, 9:   return "R5";
            8, 14:        return "R6";
            3, 5, 10, 12: return "R7";
            2, 4:         return "R8";
            default:      return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] exp);
        checks++;
        if (result_q !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, result_q, exp);
        end
    endtask

    task automatic load_op(input int code, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_en = 1'b1; fn_code = 4'(code); opnd_a = a; opnd_b = b;
        @(negedge clk);
        op_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset value", '0);

        // Exhaustive sweep: every code, every operand pair (R2 and R4..R9)
        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    load_op(c, W'(a), W'(b));
                    check({req_tag(c), " R2 sweep"}, model(c, W'(a), W'(b)));
                end
            end
        end

        // R10: no carry between positions
        load_op(6, 4'b1111, 4'b0001);
        check("R10 xor no carry", 4'b1110);
        load_op(14, 4'b1000, 4'b1000);
        check("R10 nand per bit", 4'b0111);

        // R3: hold while disabled, inputs changing
        load_op(1, 4'b1100, 4'b1010);
        check("R2 load before hold", 4'b1000);
        @(negedge clk);
        op_en = 1'b0; fn_code = 4'd15; opnd_a = 4'b0011; opnd_b = 4'b0110;
        repeat (2) @(negedge clk);
        check("R3 hold", 4'b1000);

        // R1: reset collides with a load of all ones
        @(negedge clk);
        rst = 1'b1; op_en = 1'b1; fn_code = 4'd15;
        @(negedge clk);
        check("R1 reset beats load", '0);
        rst = 1'b0; op_en = 1'b0;
        load_op(15, 4'b0000, 4'b0000);
        check("R4 ones after reset", 4'b1111);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule